// File: doc/BRIEF.md
# Banked Page-Mapping Address Translator

This block sits between an 8-bit CPU that issues 16-bit logical addresses and a system bus that carries 24-bit physical addresses. The 64K logical space is split into sixteen 4K slots. Logical bits [15:12] pick a slot, and bits [11:0] pass through untouched. The chosen slot is replaced by a 12-bit physical page number, so any 4K page of the 16 MB physical space can appear in any slot. The page tables are held as several switchable banks. Each bank has one entry per slot, and a bank register picks the bank in use. An operating system keeps a shared region by loading the same physical pages into the upper entries of every bank. A bank switch then changes only the lower slots.

The tables are loaded with port-output cycles. The port number comes from address bits [7:0], and the value written comes from address bits [15:8]. This is the value that a port-output instruction places on the high address byte. The data bus is never used, and the tables cannot be read back. Each 12-bit entry needs two writes, because one write carries only eight bits. An index register picks the entry first. While an external bus master owns the bus, its own 24-bit address is passed straight through. I/O cycles are not translated.

Top module: `banked_page_mapper`

## Requirements
- R1: After reset, the active bank is 0 and every entry of bank 0 maps logical page n to physical page n, so that logical address A appears as physical {8'h00, A}. Entries of the other banks reset to physical page 0.
- R2: Outside DMA ownership, physical bits [11:0] equal logical bits [11:0].
- R3: A write to port BASE+0 loads the entry index: bank from data bits [6:4] and page from data bits [3:0]. A write to BASE+1 replaces bits [7:0] of the indexed entry with the 8-bit data, and bits [11:8] of that entry are kept.
- R4: A write to BASE+2 replaces bits [11:8] of the indexed entry with data bits [3:0]. Data bits [7:4] are ignored, and entry bits [7:0] are kept.
- R5: A write to BASE+3 sets the active bank from data bits [2:0]. Data bits [7:3] are ignored.
- R6: A table or bank write takes effect on the clock edge that follows the end of the write strobe (iorq and wr both high). Until that edge, translation uses the old contents.
- R7: An I/O read cycle (iorq and rd high, wr low) to a mapper port changes no entry and no register.
- R8: A write to a port outside BASE+0..BASE+3 changes no entry and no register.
- R9: While dma_grant is high, phys_addr equals dma_addr, whatever the CPU inputs are.
- R10: During an I/O request without DMA, phys_addr is {8'h00, cpu_addr}, with no translation.
- R11: Banks are independent. An entry written in one bank does not appear in another, and entries loaded identically in several banks stay mapped across a bank switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus; also carries the port number and the write data |
| iorq | input | 1 | CPU I/O request |
| wr | input | 1 | CPU write strobe |
| rd | input | 1 | CPU read strobe |
| dma_grant | input | 1 | External bus master owns the bus |
| dma_addr | input | 24 | Address from the external bus master |
| phys_addr | output | 24 | Physical address onto the system bus |

## Verification
The bench checks the commit timing of a write. It samples the translation after the strobe drops but before the next edge, where the old mapping must still show, and then after that edge. A design that commits while the strobe is still active, or one cycle late, fails one of the two samples. The split entry load is checked with a high-nibble write whose data carries set upper bits. A design that took those bits, or that cleared the low byte during the nibble write, gives a wrong page. The bench also covers port reads, writes just outside the port window, bank switches where a slot is shared and a slot is not, and DMA taking priority over an I/O cycle. Each of these catches a design that decodes too widely, shares storage between banks, or gives the wrong source priority.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int LOG_W  = 16;
    localparam int PHYS_W = 24;
    localparam int OFFS_W = 12;
    localparam int PAGE_W = LOG_W - OFFS_W;
    localparam int PPN_W  = PHYS_W - OFFS_W;
    localparam int PORT_W = 8;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        K_INDEX = 2'd0,
        K_LOW   = 2'd1,
        K_HIGH  = 2'd2,
        K_BANK  = 2'd3
    } map_kind_e;

    typedef struct packed {
        logic              valid;
        map_kind_e         kind;
        logic [DATA_W-1:0] data;
    } map_cmd_t;

    function automatic logic [PHYS_W-1:0] join_addr(input logic [PPN_W-1:0] ppn,
                                                    input logic [OFFS_W-1:0] offs);
        return {ppn, offs};
    endfunction

endpackage

// File: rtl/map_port_decode.sv
module map_port_decode
    import mmu_pkg::*;
#(
    parameter logic [PORT_W-1:0] BASE_PORT = 8'hE0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOG_W-1:0] cpu_addr,
    input  logic             iorq,
    input  logic             wr,
    output map_cmd_t         cmd
);
    logic              strobe;
    logic              strobe_q;
    logic [PORT_W-1:0] port_q;
    logic [DATA_W-1:0] data_q;
    logic [PORT_W-1:0] offset;

    assign strobe = iorq & wr;
    assign offset = port_q - BASE_PORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            port_q   <= '0;
            data_q   <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe) begin
                port_q <= cpu_addr[PORT_W-1:0];
                data_q <= cpu_addr[LOG_W-1:PORT_W];
            end
        end
    end

    always_comb begin
        cmd.valid = strobe_q && !strobe && (offset < PORT_W'(4));
        cmd.kind  = map_kind_e'(offset[1:0]);
        cmd.data  = data_q;
    end

endmodule

// File: rtl/map_table.sv
module map_table
    import mmu_pkg::*;
#(
    parameter int N_BANKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  map_cmd_t          cmd,
    input  logic [PAGE_W-1:0] lookup_page,
    output logic [PPN_W-1:0]  lookup_ppn
);
    localparam int BANK_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int N_PAGES = 1 << PAGE_W;
    localparam int N_ENT   = N_BANKS * N_PAGES;
    localparam int HI_W    = PPN_W - DATA_W;

    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] idx_bank_q;
    logic [PAGE_W-1:0] idx_page_q;
    logic [PPN_W-1:0]  entry [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q     <= '0;
            idx_bank_q <= '0;
            idx_page_q <= '0;
        end else if (cmd.valid) begin
            if (cmd.kind == K_INDEX) begin
                idx_page_q <= cmd.data[PAGE_W-1:0];
                idx_bank_q <= cmd.data[PAGE_W +: BANK_W];
            end
            if (cmd.kind == K_BANK) begin
                bank_q <= cmd.data[BANK_W-1:0];
            end
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        for (genvar p = 0; p < N_PAGES; p++) begin : g_page
            localparam int E = b * N_PAGES + p;
            logic hit;
            assign hit = cmd.valid && (idx_bank_q == BANK_W'(b)) &&
                         (idx_page_q == PAGE_W'(p));
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry[E] <= (b == 0) ? PPN_W'(p) : '0;
                end else if (hit && cmd.kind == K_LOW) begin
                    entry[E][DATA_W-1:0] <= cmd.data;
                end else if (hit && cmd.kind == K_HIGH) begin
                    entry[E][PPN_W-1:DATA_W] <= cmd.data[HI_W-1:0];
                end
            end
        end
    end

    assign lookup_ppn = entry[{bank_q, lookup_page}];

    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(cmd.valid && cmd.kind == K_BANK) |=> $stable(bank_q))
        else $error("active bank changed without a bank command");

    assert_reset_bank_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_q == '0))
        else $error("active bank not zero after reset");

endmodule

// File: rtl/addr_translate.sv
module addr_translate
    import mmu_pkg::*;
(
    input  logic [LOG_W-1:0]  cpu_addr,
    input  logic              iorq,
    input  logic              dma_grant,
    input  logic [PHYS_W-1:0] dma_addr,
    input  logic [PPN_W-1:0]  ppn,
    output logic [PHYS_W-1:0] phys_addr
);
    always_comb begin
        if (dma_grant)
            phys_addr = dma_addr;
        else if (iorq)
            phys_addr = {{(PHYS_W-LOG_W){1'b0}}, cpu_addr};
        else
            phys_addr = join_addr(ppn, cpu_addr[OFFS_W-1:0]);
    end

endmodule

// File: rtl/banked_page_mapper.sv
module banked_page_mapper
    import mmu_pkg::*;
#(
    parameter logic [7:0] BASE_PORT = 8'hE0,
    parameter int         N_BANKS   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        iorq,
    input  logic        wr,
    input  logic        rd,
    input  logic        dma_grant,
    input  logic [23:0] dma_addr,
    output logic [23:0] phys_addr
);
    map_cmd_t         cmd;
    logic [PPN_W-1:0] ppn;
    logic             io_write;

    assign io_write = wr & ~rd;

    map_port_decode #(.BASE_PORT(BASE_PORT)) i_decode (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr),
        .iorq(iorq), .wr(io_write), .cmd(cmd)
    );

    map_table #(.N_BANKS(N_BANKS)) i_table (
        .clk(clk), .rst(rst), .cmd(cmd),
        .lookup_page(cpu_addr[LOG_W-1:OFFS_W]), .lookup_ppn(ppn)
    );

    addr_translate i_xlate (
        .cpu_addr(cpu_addr), .iorq(iorq), .dma_grant(dma_grant),
        .dma_addr(dma_addr), .ppn(ppn), .phys_addr(phys_addr)
    );

    assert_dma_pass_R9: assert property (@(posedge clk) disable iff (rst)
        dma_grant |-> (phys_addr == dma_addr))
        else $error("dma address not passed through");

    assert_io_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (iorq && !dma_grant) |-> (phys_addr[23:16] == 8'h00))
        else $error("io cycle drove upper physical bits");

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
        !dma_grant |-> (phys_addr[11:0] == cpu_addr[11:0]))
        else $error("page offset altered");

endmodule

// File: tb/test_banked_page_mapper.sv
module test_banked_page_mapper;

    localparam logic [7:0] BASE = 8'hE0;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        iorq, wr, rd, dma_grant;
    logic [23:0] dma_addr;
    logic [23:0] phys_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    banked_page_mapper #(.BASE_PORT(BASE)) i_banked_page_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .iorq(iorq), .wr(wr),
        .rd(rd), .dma_grant(dma_grant), .dma_addr(dma_addr), .phys_addr(phys_addr)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        io;
        logic        dma;
        logic [23:0] daddr;
        logic [23:0] expect_pa;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b0, 1'b0, 24'h0,      24'h000000},
        '{16'h5FFF, 1'b0, 1'b0, 24'h0,      24'h005FFF},
        '{16'hF123, 1'b0, 1'b0, 24'h0,      24'h00F123},
        '{16'hC001, 1'b1, 1'b0, 24'h0,      24'h00C001},
        '{16'h1234, 1'b0, 1'b1, 24'hABCDEF, 24'hABCDEF},
        '{16'hFFFF, 1'b1, 1'b1, 24'h123456, 24'h123456}
    };

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: phys_addr=%h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        iorq = 0; wr = 0; rd = 0; dma_grant = 0; dma_addr = '0;
    endtask

    task automatic look(input string req, input logic [15:0] a, input logic [23:0] exp);
        @(negedge clk);
        idle();
        cpu_addr = a;
        #1 check(req, phys_addr, exp);
    endtask

    // Port write with the value on the high address byte; strobe held two cycles.
    // Returns just after the strobe drops, before the committing edge.
    task automatic port_cycle(input logic [7:0] port, input logic [7:0] data,
                              input logic is_read, input logic [15:0] probe);
        @(negedge clk);
        cpu_addr = {data, port};
        iorq = 1; wr = !is_read; rd = is_read;
        repeat (2) @(negedge clk);
        idle();
        cpu_addr = probe;
        #1;
    endtask

    task automatic port_wr(input logic [7:0] port, input logic [7:0] data);
        port_cycle(port, data, 1'b0, 16'h0000);
    endtask

    initial begin
        idle();
        cpu_addr = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 R2 R9 R10: vector walk from the reset state
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            cpu_addr  = VECS[i].addr;
            iorq      = VECS[i].io;
            dma_grant = VECS[i].dma;
            dma_addr  = VECS[i].daddr;
            #1 check(VECS[i].dma ? "R9" : (VECS[i].io ? "R10" : "R1"),
                     phys_addr, VECS[i].expect_pa);
        end

        // R3: index bank0 page5, low byte 0x34
        port_wr(BASE + 8'd0, 8'h05);
        port_wr(BASE + 8'd1, 8'h34);
        look("R3", 16'h5ABC, 24'h034ABC);
        // R6: high nibble write; old value visible until the edge after strobe end
        port_cycle(BASE + 8'd2, 8'hF7, 1'b0, 16'h5ABC);
        check("R6", phys_addr, 24'h034ABC);
        look("R4", 16'h5ABC, 24'h734ABC);
        look("R2", 16'h5001, 24'h734001);

        // R7: port read to the low-byte port changes nothing
        port_cycle(BASE + 8'd1, 8'h99, 1'b1, 16'h5ABC);
        look("R7", 16'h5ABC, 24'h734ABC);

        // R8: writes just outside the port window
        port_wr(BASE + 8'd4, 8'h55);
        port_wr(BASE - 8'd1, 8'h02);
        port_wr(BASE + 8'd5, 8'h01);
        look("R8", 16'h5ABC, 24'h734ABC);
        look("R8", 16'h0123, 24'h000123);

        // Bank 1: page0 -> 0x100, page F -> 0x00F (shared top slot)
        port_wr(BASE + 8'd0, 8'h10);
        port_wr(BASE + 8'd1, 8'h00);
        port_wr(BASE + 8'd2, 8'h01);
        port_wr(BASE + 8'd0, 8'h1F);
        port_wr(BASE + 8'd1, 8'h0F);
        port_wr(BASE + 8'd2, 8'h00);
        look("R11", 16'h0ABC, 24'h000ABC);
        port_wr(BASE + 8'd3, 8'h01);
        look("R5", 16'h0ABC, 24'h100ABC);
        look("R11", 16'hF00D, 24'h00F00D);
        look("R11", 16'h5ABC, 24'h000ABC);
        port_wr(BASE + 8'd3, 8'hF8);
        look("R5", 16'h5ABC, 24'h734ABC);

        // R9: DMA overrides translation after programming
        @(negedge clk);
        idle();
        cpu_addr = 16'h5ABC; dma_grant = 1; dma_addr = 24'h00FEED;
        #1 check("R9", phys_addr, 24'h00FEED);

        // R1: reset restores identity map and bank 0
        port_wr(BASE + 8'd3, 8'h01);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        look("R1", 16'h5ABC, 24'h005ABC);
        look("R1", 16'h0ABC, 24'h000ABC);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule